// File: doc/BRIEF.md
# NAND Asynchronous Bus Phase Sequencer

This block turns single host requests into the strobe sequences of an asynchronous NAND flash bus that is 8 or 16 bits wide. Each request names one of three windows: command byte, address byte or data. The block then drives chip enable, the command latch line, the address latch line, the write and read strobes and the output enable of the data bus. It also returns read data to the host.

Every bus cycle passes through the same four programmed phases: an address and control settle phase, a strobe-low phase, a hold phase and, after reads only, a bus release phase. Reads and writes use the same phase counts. A control word sets enable, soft reset, ready/busy waiting, bus width and the ECC restart request. It also holds two extra settle delays that apply when a read comes straight after a command or an address cycle. The host sees a valid/ready handshake, a busy flag and a one-cycle read response pulse.

Top module: `nand_phase_seq`

## Requirements
- R1: In reset and in the first cycle after it, `nand_ce_n`, `nand_we_n` and `nand_re_n` are 1. `nand_cle`, `nand_ale`, `nand_dq_oe`, `rsp_valid`, `busy` and `ecc_restart` are 0.
- R2: `req_ready` is 1 only when all of these hold: the sequencer is idle, control bit 2 (enable) is 1, control bit 3 (NAND device select) is 1 and control bit 0 (soft reset) is 0. When control bit 1 (wait on ready/busy) is 1 and `nand_rb_n` is 0, `req_ready` is 0 and `busy` is 1. When bit 1 is 0, `nand_rb_n` has no effect.
- R3: The timing word holds setup S in bits 7:0, wait W in bits 15:8, hold H in bits 23:16 and release Z in bits 31:24. After the accepting clock edge, chip enable stays low with the strobe high for S+1 cycles. The strobe is then low for max(W,1)+1 cycles. Chip enable then stays low for max(H,1) more cycles with the strobe high.
- R4: `req_kind` 0 is a command cycle (`nand_cle` high while chip enable is low). Kind 1 is an address cycle (`nand_ale` high). Kind 2 or 3 is a data cycle (both low). Command and address cycles always use the write strobe, and `req_write` is ignored for them.
- R5: On a write cycle, `nand_dq_oe` is 1 for every cycle in which chip enable is low, and `nand_dq_o` carries the request data during that time. Only the write strobe goes low. Command and address cycles drive the byte in bits 7:0 with the upper bits at 0.
- R6: A data cycle is word-wide only when control bit 4 (16-bit bus) and `req_wide` are both 1. Otherwise the cycle is byte-wide: driven data and returned read data carry bits 7:0, and bits 15:8 are 0.
- R7: On a read, only `nand_re_n` goes low and `nand_dq_oe` stays 0. `rsp_rdata` holds `nand_dq_i` as sampled on the last strobe-low cycle. `rsp_valid` is a one-cycle pulse in the first hold cycle.
- R8: After a read with Z greater than 0, chip enable returns high and `req_ready` stays 0 for exactly Z cycles. After a write, `req_ready` returns in the first cycle with chip enable high.
- R9: A read data cycle that directly follows a command cycle gets control bits 12:9 added to its setup length. One that directly follows an address cycle gets control bits 16:13 added. Other cycles get no extra setup.
- R10: `ecc_restart` pulses for one cycle, one cycle after control bit 6 goes from 0 to 1. Bit 6 being high when reset is released produces no pulse.
- R11: Setting control bit 0 aborts any cycle in progress. In the next cycle chip enable and both strobes are high, `busy` is 0 and no read response is produced.
- R12: The write and read strobes are never low together, `nand_cle` and `nand_ale` are never high together, and `nand_dq_oe` is 0 whenever `nand_re_n` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ctrl | input | 32 | Control word (enable, soft reset, wait, width, ECC, read delays) |
| cfg_timing | input | 4*CNT_W | Four phase counts: setup, wait, hold, release |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request accepted this cycle when valid |
| req_kind | input | 2 | Window: 0 command, 1 address, 2/3 data |
| req_write | input | 1 | Data cycle direction, 1 = write |
| req_wide | input | 1 | Data cycle word-wide request |
| req_wdata | input | DATA_W | Write data or command/address byte |
| rsp_valid | output | 1 | One-cycle read data valid |
| rsp_rdata | output | DATA_W | Read data |
| busy | output | 1 | Cycle in progress or flash busy while waiting is enabled |
| ecc_restart | output | 1 | One-cycle ECC step restart pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | DATA_W | Data bus output value |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_i | input | DATA_W | Data bus input value |
| nand_rb_n | input | 1 | Ready/busy from flash, low = busy |

## Verification
The bench measures every phase length at the pins when wait and hold are programmed to zero. A design that did not clamp them would give a one-cycle strobe or no hold at all. It runs reads straight after command and address cycles: if the two extra setup fields were swapped or ignored, the setup length would come out wrong. Byte cycles on a 16-bit bus, and wide requests on an 8-bit bus, expose lane masking that leaks the upper byte. A soft reset in the middle of a long strobe would leave the strobe low or emit a stray response if the abort path were broken. An ECC bit that is already set when reset is released catches a restart detector with the wrong reset value.

// File: rtl/nandseq_pkg.sv
// Shared types and control-word bit positions for the NAND phase sequencer.
package nandseq_pkg;

    // Bus window a request targets.
    typedef enum logic [1:0] {
        KIND_CMD  = 2'd0,
        KIND_ADDR = 2'd1,
        KIND_DATA = 2'd2
    } kind_e;

    // Phase of the bus cycle in progress.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_WAIT,
        PH_HOLD,
        PH_HIZ
    } phase_e;

    // Control word bit positions.
    localparam int CTL_SRST   = 0;
    localparam int CTL_WAITEN = 1;
    localparam int CTL_EN     = 2;
    localparam int CTL_NAND   = 3;
    localparam int CTL_W16    = 4;
    localparam int CTL_ECC    = 6;
    localparam int CTL_CLR_LO = 9;
    localparam int CTL_ALR_LO = 13;
    localparam int CTL_DLY_W  = 4;

endpackage

// File: rtl/nandseq_phase_fsm.sv
// Phase sequencer: steps one bus cycle through setup, strobe, hold and release.
// Assumes phase counts stay stable while a cycle is running; wait and hold
// are clamped to a minimum of one.
module nandseq_phase_fsm
    import nandseq_pkg::*;
#(
    parameter int CNT_W = 8,
    localparam int LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             start,
    input  logic             is_read,
    input  logic [LEN_W-1:0] setup_len,
    input  logic [CNT_W-1:0] wait_cnt,
    input  logic [CNT_W-1:0] hold_cnt,
    input  logic [CNT_W-1:0] hiz_cnt,
    output phase_e           phase,
    output logic             strobe_end
);

    phase_e             phase_q;
    logic [LEN_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   wait_eff;
    logic [CNT_W-1:0]   hold_load;
    logic               cnt_zero;

    // Clamp wait to one and turn hold into a down-count load value.
    always_comb begin
        wait_eff  = (wait_cnt == '0) ? CNT_W'(1) : wait_cnt;
        hold_load = (hold_cnt == '0) ? '0 : hold_cnt - CNT_W'(1);
        cnt_zero  = (cnt_q == '0);
    end

    // Phase register and down counter.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) begin
                    phase_q <= PH_SETUP;
                    cnt_q   <= setup_len;
                end
                PH_SETUP: if (cnt_zero) begin
                    phase_q <= PH_WAIT;
                    cnt_q   <= {1'b0, wait_eff};
                end else cnt_q <= cnt_q - LEN_W'(1);
                PH_WAIT: if (cnt_zero) begin
                    phase_q <= PH_HOLD;
                    cnt_q   <= {1'b0, hold_load};
                end else cnt_q <= cnt_q - LEN_W'(1);
                PH_HOLD: if (cnt_zero) begin
                    if (is_read && hiz_cnt != '0) begin
                        phase_q <= PH_HIZ;
                        cnt_q   <= {1'b0, hiz_cnt - CNT_W'(1)};
                    end else phase_q <= PH_IDLE;
                end else cnt_q <= cnt_q - LEN_W'(1);
                PH_HIZ: if (cnt_zero) phase_q <= PH_IDLE;
                        else cnt_q <= cnt_q - LEN_W'(1);
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign phase      = phase_q;
    assign strobe_end = (phase_q == PH_WAIT) && cnt_zero;

    // R3
    wait_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_WAIT && $past(phase_q) != PH_WAIT && !abort) |=> (phase_q == PH_WAIT));

endmodule

// File: rtl/nandseq_pad_drive.sv
// Pin decode and read capture: maps the phase and the latched request onto
// the flash pins and returns read data with a one-cycle valid pulse.
// Assumes op_wide already folds in the bus-width setting.
module nandseq_pad_drive
    import nandseq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  phase_e            phase,
    input  logic              strobe_end,
    input  kind_e             op_kind,
    input  logic              op_write,
    input  logic              op_wide,
    input  logic [DATA_W-1:0] op_wdata,
    input  logic [DATA_W-1:0] nand_dq_i,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    logic              active;
    logic              strobe;
    logic [DATA_W-1:0] rd_lane;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_data_q;

    // Control and strobe pins from the current phase.
    always_comb begin
        active     = (phase == PH_SETUP) || (phase == PH_WAIT) || (phase == PH_HOLD);
        strobe     = (phase == PH_WAIT);
        nand_ce_n  = !active;
        nand_cle   = active && (op_kind == KIND_CMD);
        nand_ale   = active && (op_kind == KIND_ADDR);
        nand_we_n  = !(strobe && op_write);
        nand_re_n  = !(strobe && !op_write);
        nand_dq_oe = active && op_write;
    end

    // Lane masking for byte cycles on a wide bus.
    generate
        if (DATA_W > 8) begin : g_wide_bus
            assign nand_dq_o = op_wide ? op_wdata : {{(DATA_W-8){1'b0}}, op_wdata[7:0]};
            assign rd_lane   = op_wide ? nand_dq_i : {{(DATA_W-8){1'b0}}, nand_dq_i[7:0]};
        end else begin : g_byte_bus
            assign nand_dq_o = op_wdata;
            assign rd_lane   = nand_dq_i;
        end
    endgenerate

    // Capture read data at the last strobe-low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= strobe_end && !op_write && !abort;
            if (strobe_end && !op_write && !abort) rsp_data_q <= rd_lane;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_data_q;

    // R12
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R12
    no_cle_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));
    // R12
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_re_n |-> !nand_dq_oe);
    // R7
    rsp_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (phase == PH_HOLD && nand_re_n));

endmodule

// File: rtl/nandseq_ecc_kick.sv
// ECC step restart: pulses once when the ECC enable bit goes from low to high.
// Assumes the bit must be seen low after reset before a pulse is allowed.
module nandseq_ecc_kick (
    input  logic clk,
    input  logic rst_n,
    input  logic ecc_en,
    output logic ecc_restart
);

    logic prev_q;
    logic pulse_q;

    // Edge detector with the history bit reset high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b1;
            pulse_q <= 1'b0;
        end else begin
            prev_q  <= ecc_en;
            pulse_q <= ecc_en && !prev_q;
        end
    end

    assign ecc_restart = pulse_q;

    // R10
    ecc_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_restart |=> !ecc_restart);

endmodule

// File: rtl/nand_phase_seq.sv
// NAND asynchronous bus phase sequencer top: accepts host requests, latches
// them, applies read-after-command/address extra settle and drives the pins.
// Assumes cfg_ctrl and cfg_timing change only while no cycle runs, except
// the soft reset bit.
module nand_phase_seq
    import nandseq_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    localparam int LEN_W = CNT_W + 1,
    localparam int TIM_W = 4 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_ctrl,
    input  logic [TIM_W-1:0]  cfg_timing,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              busy,
    output logic              ecc_restart,
    output logic              nand_ce_n,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_we_n,
    output logic              nand_re_n,
    output logic [DATA_W-1:0] nand_dq_o,
    output logic              nand_dq_oe,
    input  logic [DATA_W-1:0] nand_dq_i,
    input  logic              nand_rb_n
);

    phase_e               phase;
    logic                 strobe_end;
    logic                 soft_rst, wait_en, bus_en, nand_sel, bus16;
    logic                 rb_block, accept;
    logic [CTL_DLY_W-1:0] dly_cmd, dly_addr, extra;
    logic [LEN_W-1:0]     setup_len;
    kind_e                kind_in;
    kind_e                op_kind_q, last_kind_q;
    logic                 op_write_q, op_wide_q;
    logic [DATA_W-1:0]    op_wdata_q;
    logic                 ctrl_unused;

    assign ctrl_unused = ^{cfg_ctrl[31:17], cfg_ctrl[8:7], cfg_ctrl[5]};

    // Decode control bits and the handshake.
    always_comb begin
        soft_rst  = cfg_ctrl[CTL_SRST];
        wait_en   = cfg_ctrl[CTL_WAITEN];
        bus_en    = cfg_ctrl[CTL_EN];
        nand_sel  = cfg_ctrl[CTL_NAND];
        bus16     = cfg_ctrl[CTL_W16] && (DATA_W > 8);
        dly_cmd   = cfg_ctrl[CTL_CLR_LO +: CTL_DLY_W];
        dly_addr  = cfg_ctrl[CTL_ALR_LO +: CTL_DLY_W];
        rb_block  = wait_en && !nand_rb_n;
        req_ready = (phase == PH_IDLE) && bus_en && nand_sel && !soft_rst && !rb_block;
        accept    = req_valid && req_ready;
        busy      = (phase != PH_IDLE) || rb_block;
    end

    // Request kind and extra settle for reads after command or address.
    always_comb begin
        kind_in = (req_kind == 2'd0) ? KIND_CMD : (req_kind == 2'd1) ? KIND_ADDR : KIND_DATA;
        extra   = '0;
        if (kind_in == KIND_DATA && !req_write) begin
            if (last_kind_q == KIND_CMD)       extra = dly_cmd;
            else if (last_kind_q == KIND_ADDR) extra = dly_addr;
        end
        setup_len = {1'b0, cfg_timing[CNT_W-1:0]} + LEN_W'(extra);
    end

    // Latch the accepted request and remember its kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_kind_q   <= KIND_DATA;
            last_kind_q <= KIND_DATA;
            op_write_q  <= 1'b1;
            op_wide_q   <= 1'b0;
            op_wdata_q  <= '0;
        end else if (accept) begin
            op_kind_q   <= kind_in;
            last_kind_q <= kind_in;
            op_write_q  <= (kind_in != KIND_DATA) || req_write;
            op_wide_q   <= bus16 && req_wide && (kind_in == KIND_DATA);
            op_wdata_q  <= req_wdata;
        end
    end

    nandseq_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (soft_rst),
        .start      (accept),
        .is_read    (!op_write_q),
        .setup_len  (setup_len),
        .wait_cnt   (cfg_timing[CNT_W +: CNT_W]),
        .hold_cnt   (cfg_timing[2*CNT_W +: CNT_W]),
        .hiz_cnt    (cfg_timing[3*CNT_W +: CNT_W]),
        .phase      (phase),
        .strobe_end (strobe_end)
    );

    nandseq_pad_drive #(.DATA_W(DATA_W)) u_pads (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (soft_rst),
        .phase      (phase),
        .strobe_end (strobe_end),
        .op_kind    (op_kind_q),
        .op_write   (op_write_q),
        .op_wide    (op_wide_q),
        .op_wdata   (op_wdata_q),
        .nand_dq_i  (nand_dq_i),
        .nand_ce_n  (nand_ce_n),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_we_n  (nand_we_n),
        .nand_re_n  (nand_re_n),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata)
    );

    nandseq_ecc_kick u_ecc (
        .clk         (clk),
        .rst_n       (rst_n),
        .ecc_en      (cfg_ctrl[CTL_ECC]),
        .ecc_restart (ecc_restart)
    );

    // R2
    accept_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (phase == PH_SETUP || soft_rst));

endmodule

// File: tb/nand_phase_seq_tb.sv
`timescale 1ns/100ps
// Bench: a vector table of bus cycles walked by one loop, then directed tests.
module nand_phase_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_ctrl, cfg_timing;
    logic        req_valid, req_ready, req_write, req_wide;
    logic [1:0]  req_kind;
    logic [15:0] req_wdata, rsp_rdata, nand_dq_o, nand_dq_i;
    logic        rsp_valid, busy, ecc_restart;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe, nand_rb_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    nand_phase_seq dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_ctrl(cfg_ctrl), .cfg_timing(cfg_timing),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_write(req_write), .req_wide(req_wide), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .busy(busy),
        .ecc_restart(ecc_restart), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
        .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
        .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe), .nand_dq_i(nand_dq_i),
        .nand_rb_n(nand_rb_n)
    );

    // Base control: enable, NAND select, ready/busy wait, ECC bit, delays 3 and 5.
    localparam logic [31:0] CTL_BASE = 32'h0000A64E;

    localparam int NV = 8;
    localparam logic [31:0] V_TIM  [NV] = '{32'h00010201, 32'h03020300, 32'h00000000, 32'h02010002,
                                           32'h00040105, 32'h00000300, 32'h01000000, 32'h00000000};
    localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd2, 2'd1, 2'd2, 2'd2, 2'd3, 2'd0, 2'd2};
    localparam logic        V_WR   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam logic        V_WIDE [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic        V_B16  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0};
    localparam logic [15:0] V_WD   [NV] = '{16'h0070, 16'h0000, 16'h00C3, 16'h0000,
                                           16'h1234, 16'h3456, 16'hFF90, 16'h0000};
    localparam logic [15:0] V_DIN  [NV] = '{16'h0000, 16'hA55A, 16'h0000, 16'hBEEF,
                                           16'h0000, 16'h0000, 16'h0000, 16'hCAFE};

    task automatic check_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Issue one request and measure its phases at the pins.
    task automatic run_op(input logic [1:0] kind, input logic wr, input logic wide,
                          input logic [15:0] wd, input logic [15:0] exp_bus,
                          output int su, output int lo, output int ho, output int hz,
                          output int pins_ok, output int rsp_n, output logic [15:0] rsp_d,
                          output int rsp_first);
        int g;
        int seen_low;
        logic effw;
        effw = (kind != 2'd2 && kind != 2'd3) || wr;
        su = 0; lo = 0; ho = 0; hz = 0; pins_ok = 1; rsp_n = 0; rsp_d = '0; rsp_first = 0;
        seen_low = 0; g = 0;
        @(negedge clk);
        req_kind = kind; req_write = wr; req_wide = wide; req_wdata = wd; req_valid = 1'b1;
        while (!req_ready && g < 100) begin @(negedge clk); g++; end
        @(negedge clk);
        req_valid = 1'b0;
        g = 0;
        while (!nand_ce_n && g < 5000) begin
            if (!nand_we_n && !nand_re_n) pins_ok = 0;
            if (nand_cle !== (kind == 2'd0)) pins_ok = 0;
            if (nand_ale !== (kind == 2'd1)) pins_ok = 0;
            if (nand_dq_oe !== effw) pins_ok = 0;
            if (effw && nand_dq_o !== exp_bus) pins_ok = 0;
            if (effw ? !nand_re_n : !nand_we_n) pins_ok = 0;
            if (!(nand_we_n && nand_re_n)) begin lo++; seen_low = 1; end
            else if (!seen_low) su++;
            else begin
                ho++;
                if (rsp_valid && ho == 1) rsp_first = 1;
            end
            if (rsp_valid) begin rsp_n++; rsp_d = rsp_rdata; end
            @(negedge clk); g++;
        end
        while (!req_ready && g < 5000) begin hz++; @(negedge clk); g++; end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int prev_kind;
        rst_n = 1'b0; cfg_ctrl = CTL_BASE; cfg_timing = '0;
        req_valid = 1'b0; req_kind = '0; req_write = 1'b0; req_wide = 1'b0; req_wdata = '0;
        nand_dq_i = '0; nand_rb_n = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1 ce_n in reset", nand_ce_n, 1);
        check_eq("R1 dq_oe in reset", nand_dq_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1 strobes idle", {nand_we_n, nand_re_n, nand_ce_n}, 3'b111);
        check_eq("R1 latch lines", {nand_cle, nand_ale, nand_dq_oe}, 0);
        check_eq("R1 rsp/busy", {rsp_valid, busy}, 0);
        check_eq("R10 no restart pulse after reset", ecc_restart, 0);
        check_eq("R2 ready when idle", req_ready, 1);

        // Vector walk: R3 R4 R5 R6 R7 R8 R9.
        prev_kind = 2;
        for (int v = 0; v < NV; v++) begin
            int s, w, h, z, extra, is_rd, wide_eff;
            int su, lo, ho, hz, pins_ok, rsp_n, rsp_first;
            logic [15:0] rsp_d, exp_bus, exp_rd;
            s = V_TIM[v][7:0]; w = V_TIM[v][15:8]; h = V_TIM[v][23:16]; z = V_TIM[v][31:24];
            is_rd = (V_KIND[v] >= 2) && !V_WR[v];
            extra = is_rd ? ((prev_kind == 0) ? 3 : (prev_kind == 1) ? 5 : 0) : 0;
            wide_eff = V_B16[v] && V_WIDE[v] && (V_KIND[v] >= 2);
            exp_bus = wide_eff ? V_WD[v] : (V_WD[v] & 16'h00FF);
            exp_rd  = wide_eff ? V_DIN[v] : (V_DIN[v] & 16'h00FF);
            cfg_ctrl = CTL_BASE | (32'(V_B16[v]) << 4);
            cfg_timing = V_TIM[v];
            nand_dq_i = V_DIN[v];
            run_op(V_KIND[v], V_WR[v], V_WIDE[v], V_WD[v], exp_bus,
                   su, lo, ho, hz, pins_ok, rsp_n, rsp_d, rsp_first);
            check_eq($sformatf("R3 R9 setup length v%0d", v), su, s + 1 + extra);
            check_eq($sformatf("R3 strobe low length v%0d", v), lo, ((w == 0) ? 1 : w) + 1);
            check_eq($sformatf("R3 hold length v%0d", v), ho, (h == 0) ? 1 : h);
            check_eq($sformatf("R8 release length v%0d", v), hz, is_rd ? z : 0);
            check_eq($sformatf("R4 R5 R12 pin levels v%0d", v), pins_ok, 1);
            if (is_rd) begin
                check_eq($sformatf("R7 response count v%0d", v), rsp_n, 1);
                check_eq($sformatf("R7 response in first hold cycle v%0d", v), rsp_first, 1);
                check_eq($sformatf("R6 R7 read data v%0d", v), rsp_d, exp_rd);
            end else begin
                check_eq($sformatf("R7 no response on write v%0d", v), rsp_n, 0);
            end
            prev_kind = (V_KIND[v] >= 2) ? 2 : V_KIND[v];
        end

        // R2: gating of the handshake.
        @(negedge clk);
        cfg_ctrl = CTL_BASE & ~32'h4; #1;
        check_eq("R2 ready low when disabled", req_ready, 0);
        cfg_ctrl = CTL_BASE & ~32'h8; #1;
        check_eq("R2 ready low without NAND select", req_ready, 0);
        cfg_ctrl = CTL_BASE; nand_rb_n = 1'b0; #1;
        check_eq("R2 ready low while flash busy", req_ready, 0);
        check_eq("R2 busy high while flash busy", busy, 1);
        cfg_ctrl = CTL_BASE & ~32'h2; #1;
        check_eq("R2 ready/busy ignored when wait off", req_ready, 1);
        check_eq("R2 busy low when wait off", busy, 0);
        nand_rb_n = 1'b1; cfg_ctrl = CTL_BASE;

        // R10: restart pulse after clear then set.
        @(negedge clk); cfg_ctrl = CTL_BASE & ~32'h40;
        @(negedge clk); check_eq("R10 no pulse on clear", ecc_restart, 0);
        cfg_ctrl = CTL_BASE;
        @(negedge clk); check_eq("R10 pulse after set", ecc_restart, 1);
        @(negedge clk); check_eq("R10 pulse is one cycle", ecc_restart, 0);

        // R11: abort a long read strobe.
        cfg_timing = 32'h0000C800;
        req_kind = 2'd2; req_write = 1'b0; req_wide = 1'b0; req_valid = 1'b1;
        @(negedge clk); req_valid = 1'b0;
        for (int g = 0; g < 20 && nand_re_n; g++) @(negedge clk);
        check_eq("R11 strobe low before abort", nand_re_n, 0);
        cfg_ctrl = CTL_BASE | 32'h1;
        @(negedge clk);
        check_eq("R11 pins released after abort", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
        check_eq("R11 busy clear after abort", busy, 0);
        check_eq("R11 ready low in soft reset", req_ready, 0);
        check_eq("R11 no response after abort", rsp_valid, 0);
        cfg_ctrl = CTL_BASE; #1;
        check_eq("R11 ready after soft reset cleared", req_ready, 1);

        finish_run();
    end

endmodule